// File: doc/BRIEF.md
# Prioritised message object buffer

This block holds the message objects of a CAN controller and decides which object a frame lands in and which frame leaves next. Each object is configured as a receive or a transmit slot. A frame that arrives from the bit engine as one parallel record is stored in the lowest-numbered receive object that accepts it. Receive objects that share an identifier filter form a chain. Incoming frames fill the chain from the lowest free member. The chain ends at an object marked end-of-chain, and that last object is overwritten when it is still full, with a lost flag raised.

On the transmit side the block presents the lowest-numbered valid transmit object that has a pending request, as a registered record. When the bit engine reports success for an object, the request of that object is dropped and its pending-interrupt flag is raised. Software configures objects, acknowledges flags and reads objects back through simple indexed ports. It watches two flag bitmaps and one interrupt line.

Objects are numbered 0 to NUM_OBJ-1 in this block: index 0 is the highest-priority object. With the defaults there are 32 objects and the bitmaps split them at index 16.

Top module: `mob_buffer`

## Requirements
- R1: After reset, every object is invalid and every flag is clear: `newdat_map`, `txdone_map`, `tx_pend`, `rx_stored`, `rx_lost` and `irq` are all 0.
- R2: A frame offered with `rx_valid` is stored in the lowest-indexed accepting object. On the next clock edge that object's new-data and interrupt-pending flags are set, `rx_stored` is 1 and `rx_obj` holds its index.
- R3: Without `cfg_use_mask`, an object accepts only an identical 29-bit identifier and an identical extended flag. With `cfg_use_mask`, a 0 in `cfg_mask` ignores that identifier bit, and `cfg_mask_xtd` = 1 makes the extended flag take part in the comparison.
- R4: A receive object that is not end-of-chain and already holds new data is passed over. The frame goes to the next accepting object, so a chain fills in index order.
- R5: An end-of-chain object that still holds new data is overwritten by a matching frame, its lost flag is set and `rx_lost` is 1. A frame that finds no accepting object is dropped: `rx_stored` stays 0 and no stored object changes.
- R6: An object whose valid bit is 0 takes part in neither reception nor transmission. A transmit-direction object never receives.
- R7: Of the valid transmit objects with a pending request, the lowest-indexed one is presented. Two clock edges after the write that sets its request, `tx_pend` is 1 and `tx_obj`, `tx_id`, `tx_xtd`, `tx_dlc` and `tx_data` describe it.
- R8: `tx_done` with `tx_done_idx` naming an object that has a pending request clears that request and sets its interrupt-pending flag, and the next pending object is then presented. `tx_done` for an object without a request changes nothing.
- R9: `newdat_map` bit k is the new-data flag of object k (k < SPLIT). `txdone_map` bit k is the interrupt-pending flag of object SPLIT+k.
- R10: `irq` is 1 one edge after any valid object has interrupt-pending set together with its matching enable (`cfg_tx_ie` for transmit objects, `cfg_rx_ie` for receive objects). Otherwise it is 0.
- R11: `clr_we` clears the new-data, interrupt-pending and lost flags of object `clr_idx`. A frame stored into the same object in the same cycle wins, and its flags end up set.
- R12: One edge after `rd_idx` is applied, `rd_id`, `rd_xtd`, `rd_dlc`, `rd_data` and the three flags show that object. A received frame replaces the stored identifier, extended flag, length and payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write configuration of object `cfg_idx`; clears its flags |
| cfg_idx | input | 5 | Object to configure |
| cfg_valid | input | 1 | Object takes part in traffic |
| cfg_dir_tx | input | 1 | 1 = transmit object, 0 = receive object |
| cfg_xtd | input | 1 | Extended-identifier flag |
| cfg_id | input | 29 | Identifier |
| cfg_mask | input | 29 | Acceptance mask, 1 = compare bit |
| cfg_mask_xtd | input | 1 | Compare extended flag under mask |
| cfg_use_mask | input | 1 | Apply the acceptance mask |
| cfg_eob | input | 1 | Object ends a receive chain |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| cfg_tx_req | input | 1 | Transmit request |
| cfg_dlc | input | 4 | Data length code |
| cfg_data | input | 64 | Payload |
| clr_we | input | 1 | Acknowledge flags of object `clr_idx` |
| clr_idx | input | 5 | Object to acknowledge |
| rx_valid | input | 1 | Received frame offered this cycle |
| rx_id | input | 29 | Received identifier |
| rx_xtd | input | 1 | Received extended flag |
| rx_dlc | input | 4 | Received length |
| rx_data | input | 64 | Received payload |
| rx_stored | output | 1 | Last offered frame was stored |
| rx_obj | output | 5 | Object that took it |
| rx_lost | output | 1 | Store overwrote unread data |
| tx_pend | output | 1 | A transmit object is presented |
| tx_obj | output | 5 | Presented object |
| tx_id | output | 29 | Its identifier |
| tx_xtd | output | 1 | Its extended flag |
| tx_dlc | output | 4 | Its length |
| tx_data | output | 64 | Its payload |
| tx_done | input | 1 | Successful transmission report |
| tx_done_idx | input | 5 | Object that was sent |
| rd_idx | input | 5 | Object to read back |
| rd_id | output | 29 | Read identifier |
| rd_xtd | output | 1 | Read extended flag |
| rd_dlc | output | 4 | Read length |
| rd_data | output | 64 | Read payload |
| rd_newdat | output | 1 | Read new-data flag |
| rd_intpnd | output | 1 | Read interrupt-pending flag |
| rd_msglst | output | 1 | Read lost flag |
| newdat_map | output | 16 | New-data flags of the lower objects |
| txdone_map | output | 16 | Interrupt-pending flags of the upper objects |
| irq | output | 1 | Interrupt request |

## Verification
Reception is tried with exact identifiers and with identifiers that differ only in the extended flag, a single bit or the masked-out low bits. These patterns separate a correct filter from one that ignores the mask, the extended flag or the compare mode. Frames aimed at an invalid object and at a transmit object, with an accepting object sitting behind them, show whether disqualified objects are skipped. A burst of identical frames into a three-object chain shows in-order filling and overwrite of the end-of-chain object, and a two-frame burst into a lone non-terminal object shows a drop. Transmit requests set out of index order, one of them on an invalid object, show that priority comes from the index and not from the order of the writes.

// File: rtl/mob_pkg.sv
package mob_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  // Per-object attributes that the selection logic needs in parallel.
  typedef struct packed {
    logic              msg_valid;
    logic              dir_tx;
    logic              xtd;
    logic [ID_W-1:0]   id;
    logic [ID_W-1:0]   mask;
    logic              mask_xtd;
    logic              use_mask;
    logic              eob;
    logic              rx_ie;
    logic              tx_ie;
    logic [DLC_W-1:0]  dlc;
  } obj_attr_t;
endpackage

// File: rtl/mob_prio_pick.sv
module mob_prio_pick #(
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  // Lowest index wins: scan downwards so the last hit is the smallest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  // R7
  pick_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

  // R2
  pick_none_chk: assert property (@(posedge clk) disable iff (rst)
    !found |-> (req == '0));
endmodule

// File: rtl/mob_match.sv
module mob_match
  import mob_pkg::*;
#(
  parameter int N = 32
) (
  input  obj_attr_t [N-1:0] attr,
  input  logic [N-1:0]      newdat,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_xtd,
  output logic [N-1:0]      accept
);
  for (genvar g = 0; g < N; g++) begin : g_obj
    logic [ID_W-1:0] care;
    logic            id_ok;
    logic            xtd_ok;
    logic            room;

    assign care   = attr[g].use_mask ? attr[g].mask : '1;
    assign id_ok  = ((rx_id ^ attr[g].id) & care) == '0;
    assign xtd_ok = (attr[g].use_mask && !attr[g].mask_xtd) ||
                    (rx_xtd == attr[g].xtd);
    // A full object only takes a frame when it closes its chain.
    assign room   = !newdat[g] || attr[g].eob;
    assign accept[g] = attr[g].msg_valid && !attr[g].dir_tx &&
                       id_ok && xtd_ok && room;
  end
endmodule

// File: rtl/mob_payload_ram.sv
module mob_payload_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mob_buffer.sv
module mob_buffer
  import mob_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int SPLIT   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_OBJ)-1:0] cfg_idx,
  input  logic                       cfg_valid,
  input  logic                       cfg_dir_tx,
  input  logic                       cfg_xtd,
  input  logic [ID_W-1:0]            cfg_id,
  input  logic [ID_W-1:0]            cfg_mask,
  input  logic                       cfg_mask_xtd,
  input  logic                       cfg_use_mask,
  input  logic                       cfg_eob,
  input  logic                       cfg_rx_ie,
  input  logic                       cfg_tx_ie,
  input  logic                       cfg_tx_req,
  input  logic [DLC_W-1:0]           cfg_dlc,
  input  logic [DATA_W-1:0]          cfg_data,
  input  logic                       clr_we,
  input  logic [$clog2(NUM_OBJ)-1:0] clr_idx,
  input  logic                       rx_valid,
  input  logic [ID_W-1:0]            rx_id,
  input  logic                       rx_xtd,
  input  logic [DLC_W-1:0]           rx_dlc,
  input  logic [DATA_W-1:0]          rx_data,
  output logic                       rx_stored,
  output logic [$clog2(NUM_OBJ)-1:0] rx_obj,
  output logic                       rx_lost,
  output logic                       tx_pend,
  output logic [$clog2(NUM_OBJ)-1:0] tx_obj,
  output logic [ID_W-1:0]            tx_id,
  output logic                       tx_xtd,
  output logic [DLC_W-1:0]           tx_dlc,
  output logic [DATA_W-1:0]          tx_data,
  input  logic                       tx_done,
  input  logic [$clog2(NUM_OBJ)-1:0] tx_done_idx,
  input  logic [$clog2(NUM_OBJ)-1:0] rd_idx,
  output logic [ID_W-1:0]            rd_id,
  output logic                       rd_xtd,
  output logic [DLC_W-1:0]           rd_dlc,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_newdat,
  output logic                       rd_intpnd,
  output logic                       rd_msglst,
  output logic [SPLIT-1:0]           newdat_map,
  output logic [NUM_OBJ-SPLIT-1:0]   txdone_map,
  output logic                       irq
);
  localparam int IW     = $clog2(NUM_OBJ);
  localparam int RD_PORTS = 2;   // 0: host readback, 1: transmit record

  obj_attr_t [NUM_OBJ-1:0] attr_q;
  logic [NUM_OBJ-1:0] newdat_q, intpnd_q, msglst_q, txrq_q;

  // ---------------- receive selection ----------------
  logic [NUM_OBJ-1:0] rx_accept;
  logic               st_found;
  logic [IW-1:0]      st_idx;
  logic               st_hit;
  logic               st_ovw;

  mob_match #(.N(NUM_OBJ)) u_match (
    .attr   (attr_q),
    .newdat (newdat_q),
    .rx_id  (rx_id),
    .rx_xtd (rx_xtd),
    .accept (rx_accept)
  );

  mob_prio_pick #(.N(NUM_OBJ)) u_rx_pick (
    .clk   (clk),
    .rst   (rst),
    .req   (rx_accept),
    .found (st_found),
    .idx   (st_idx)
  );

  assign st_hit = rx_valid && st_found;
  assign st_ovw = newdat_q[st_idx];

  // ---------------- transmit selection ----------------
  logic [NUM_OBJ-1:0] tx_cand;
  logic [NUM_OBJ-1:0] irq_src;
  logic               tx_found;
  logic [IW-1:0]      tx_idx;

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    assign tx_cand[g] = attr_q[g].msg_valid && attr_q[g].dir_tx && txrq_q[g];
    assign irq_src[g] = attr_q[g].msg_valid && intpnd_q[g] &&
                        (attr_q[g].dir_tx ? attr_q[g].tx_ie : attr_q[g].rx_ie);
  end

  mob_prio_pick #(.N(NUM_OBJ)) u_tx_pick (
    .clk   (clk),
    .rst   (rst),
    .req   (tx_cand),
    .found (tx_found),
    .idx   (tx_idx)
  );

  // ---------------- payload storage ----------------
  logic              pw_we;
  logic [IW-1:0]     pw_addr;
  logic [DATA_W-1:0] pw_data;
  logic [IW-1:0]     pr_addr [RD_PORTS];
  logic [DATA_W-1:0] pr_data [RD_PORTS];

  assign pw_we      = st_hit || cfg_we;
  assign pw_addr    = st_hit ? st_idx  : cfg_idx;
  assign pw_data    = st_hit ? rx_data : cfg_data;
  assign pr_addr[0] = rd_idx;
  assign pr_addr[1] = tx_idx;

  // One copy per read port, all written alike, so each maps to a plain RAM.
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_ram
    mob_payload_ram #(.DEPTH(NUM_OBJ), .WIDTH(DATA_W)) u_ram (
      .clk   (clk),
      .we    (pw_we),
      .waddr (pw_addr),
      .wdata (pw_data),
      .raddr (pr_addr[p]),
      .rdata (pr_data[p])
    );
  end

  assign rd_data = pr_data[0];
  assign tx_data = pr_data[1];

  // ---------------- object state ----------------
  // Later statements win: completion, acknowledge, frame store, host config.
  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q   <= '0;
      newdat_q <= '0;
      intpnd_q <= '0;
      msglst_q <= '0;
      txrq_q   <= '0;
    end else begin
      if (tx_done && txrq_q[tx_done_idx]) begin
        txrq_q[tx_done_idx]   <= 1'b0;
        intpnd_q[tx_done_idx] <= 1'b1;
      end
      if (clr_we) begin
        newdat_q[clr_idx] <= 1'b0;
        intpnd_q[clr_idx] <= 1'b0;
        msglst_q[clr_idx] <= 1'b0;
      end
      if (st_hit) begin
        newdat_q[st_idx]   <= 1'b1;
        intpnd_q[st_idx]   <= 1'b1;
        if (st_ovw) msglst_q[st_idx] <= 1'b1;
        attr_q[st_idx].id  <= rx_id;
        attr_q[st_idx].xtd <= rx_xtd;
        attr_q[st_idx].dlc <= rx_dlc;
      end
      if (cfg_we) begin
        attr_q[cfg_idx].msg_valid <= cfg_valid;
        attr_q[cfg_idx].dir_tx    <= cfg_dir_tx;
        attr_q[cfg_idx].xtd       <= cfg_xtd;
        attr_q[cfg_idx].id        <= cfg_id;
        attr_q[cfg_idx].mask      <= cfg_mask;
        attr_q[cfg_idx].mask_xtd  <= cfg_mask_xtd;
        attr_q[cfg_idx].use_mask  <= cfg_use_mask;
        attr_q[cfg_idx].eob       <= cfg_eob;
        attr_q[cfg_idx].rx_ie     <= cfg_rx_ie;
        attr_q[cfg_idx].tx_ie     <= cfg_tx_ie;
        attr_q[cfg_idx].dlc       <= cfg_dlc;
        newdat_q[cfg_idx]         <= 1'b0;
        intpnd_q[cfg_idx]         <= 1'b0;
        msglst_q[cfg_idx]         <= 1'b0;
        txrq_q[cfg_idx]           <= cfg_tx_req;
      end
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_stored <= 1'b0;
      rx_obj    <= '0;
      rx_lost   <= 1'b0;
      tx_pend   <= 1'b0;
      tx_obj    <= '0;
      tx_id     <= '0;
      tx_xtd    <= 1'b0;
      tx_dlc    <= '0;
      irq       <= 1'b0;
      rd_id     <= '0;
      rd_xtd    <= 1'b0;
      rd_dlc    <= '0;
      rd_newdat <= 1'b0;
      rd_intpnd <= 1'b0;
      rd_msglst <= 1'b0;
    end else begin
      rx_stored <= st_hit;
      rx_obj    <= st_idx;
      rx_lost   <= st_hit && st_ovw;
      tx_pend   <= tx_found;
      tx_obj    <= tx_idx;
      tx_id     <= attr_q[tx_idx].id;
      tx_xtd    <= attr_q[tx_idx].xtd;
      tx_dlc    <= attr_q[tx_idx].dlc;
      irq       <= |irq_src;
      rd_id     <= attr_q[rd_idx].id;
      rd_xtd    <= attr_q[rd_idx].xtd;
      rd_dlc    <= attr_q[rd_idx].dlc;
      rd_newdat <= newdat_q[rd_idx];
      rd_intpnd <= intpnd_q[rd_idx];
      rd_msglst <= msglst_q[rd_idx];
    end
  end

  assign newdat_map = newdat_q[SPLIT-1:0];
  assign txdone_map = intpnd_q[NUM_OBJ-1:SPLIT];

  // ---------------- assertions ----------------
  // R2
  store_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (st_hit && !(cfg_we && cfg_idx == st_idx)) |=>
      (newdat_q[$past(st_idx)] && intpnd_q[$past(st_idx)] && rx_stored));

  // R5
  overwrite_lost_chk: assert property (@(posedge clk) disable iff (rst)
    (st_hit && st_ovw && !(cfg_we && cfg_idx == st_idx)) |=>
      (msglst_q[$past(st_idx)] && rx_lost));

  // R6
  rx_target_chk: assert property (@(posedge clk) disable iff (rst)
    st_hit |-> (attr_q[st_idx].msg_valid && !attr_q[st_idx].dir_tx));

  // R6
  tx_target_chk: assert property (@(posedge clk) disable iff (rst)
    tx_found |-> (attr_q[tx_idx].msg_valid && attr_q[tx_idx].dir_tx));

  // R8
  txdone_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_done && txrq_q[tx_done_idx] && !(cfg_we && cfg_idx == tx_done_idx)) |=>
      (!txrq_q[$past(tx_done_idx)] && intpnd_q[$past(tx_done_idx)]));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(intpnd_q != '0));
endmodule

// File: tb/mob_buffer_tb.sv
module mob_buffer_tb;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        cfg_we = 0, cfg_valid = 0, cfg_dir_tx = 0, cfg_xtd = 0;
  logic [4:0]  cfg_idx = '0;
  logic [28:0] cfg_id = '0, cfg_mask = '0;
  logic        cfg_mask_xtd = 0, cfg_use_mask = 0, cfg_eob = 0;
  logic        cfg_rx_ie = 0, cfg_tx_ie = 0, cfg_tx_req = 0;
  logic [3:0]  cfg_dlc = '0;
  logic [63:0] cfg_data = '0;
  logic        clr_we = 0;
  logic [4:0]  clr_idx = '0;
  logic        rx_valid = 0, rx_xtd = 0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        tx_done = 0;
  logic [4:0]  tx_done_idx = '0;
  logic [4:0]  rd_idx = '0;

  logic        rx_stored, rx_lost, tx_pend, tx_xtd, irq;
  logic [4:0]  rx_obj, tx_obj;
  logic [28:0] tx_id, rd_id;
  logic [3:0]  tx_dlc, rd_dlc;
  logic [63:0] tx_data, rd_data;
  logic        rd_xtd, rd_newdat, rd_intpnd, rd_msglst;
  logic [15:0] newdat_map, txdone_map;

  mob_buffer u_dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_dir_tx(cfg_dir_tx), .cfg_xtd(cfg_xtd), .cfg_id(cfg_id),
    .cfg_mask(cfg_mask), .cfg_mask_xtd(cfg_mask_xtd),
    .cfg_use_mask(cfg_use_mask), .cfg_eob(cfg_eob), .cfg_rx_ie(cfg_rx_ie),
    .cfg_tx_ie(cfg_tx_ie), .cfg_tx_req(cfg_tx_req), .cfg_dlc(cfg_dlc),
    .cfg_data(cfg_data), .clr_we(clr_we), .clr_idx(clr_idx),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_xtd(rx_xtd), .rx_dlc(rx_dlc),
    .rx_data(rx_data), .rx_stored(rx_stored), .rx_obj(rx_obj),
    .rx_lost(rx_lost), .tx_pend(tx_pend), .tx_obj(tx_obj), .tx_id(tx_id),
    .tx_xtd(tx_xtd), .tx_dlc(tx_dlc), .tx_data(tx_data),
    .tx_done(tx_done), .tx_done_idx(tx_done_idx), .rd_idx(rd_idx),
    .rd_id(rd_id), .rd_xtd(rd_xtd), .rd_dlc(rd_dlc), .rd_data(rd_data),
    .rd_newdat(rd_newdat), .rd_intpnd(rd_intpnd), .rd_msglst(rd_msglst),
    .newdat_map(newdat_map), .txdone_map(txdone_map), .irq(irq)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  task automatic chk(input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_obj(input int idx, input bit valid, input bit dtx,
                         input bit xtd, input logic [28:0] id,
                         input logic [28:0] mask, input bit mxtd,
                         input bit umask, input bit eob, input bit rxie,
                         input bit txie, input bit req,
                         input logic [3:0] dlc, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'(idx); cfg_valid = valid; cfg_dir_tx = dtx;
    cfg_xtd = xtd; cfg_id = id; cfg_mask = mask; cfg_mask_xtd = mxtd;
    cfg_use_mask = umask; cfg_eob = eob; cfg_rx_ie = rxie;
    cfg_tx_ie = txie; cfg_tx_req = req; cfg_dlc = dlc; cfg_data = data;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [28:0] id, input bit xtd,
                      input logic [3:0] dlc, input logic [63:0] data);
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_xtd = xtd; rx_dlc = dlc; rx_data = data;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic ack(input int idx);
    @(negedge clk);
    clr_we = 1; clr_idx = 5'(idx);
    @(negedge clk);
    clr_we = 0;
  endtask

  task automatic readback(input int idx);
    @(negedge clk);
    rd_idx = 5'(idx);
    @(negedge clk);
  endtask

  task automatic finish_tx(input int idx);
    @(negedge clk);
    tx_done = 1; tx_done_idx = 5'(idx);
    @(negedge clk);
    tx_done = 0;
    @(negedge clk);
  endtask

  // Receive filter table: identifier, extended flag, stored?, object.
  typedef struct packed {
    logic [28:0] id;
    logic        xtd;
    logic        hit;
    logic [4:0]  obj;
  } rxv_t;

  localparam int NV = 9;
  localparam rxv_t RXV [NV] = '{
    '{29'h100,     1'b0, 1'b1, 5'd0},  // exact match
    '{29'h100,     1'b1, 1'b0, 5'd0},  // extended flag differs
    '{29'h101,     1'b0, 1'b0, 5'd0},  // one identifier bit differs
    '{29'h200,     1'b0, 1'b1, 5'd3},  // invalid 1 and transmit 2 skipped
    '{29'h3A5,     1'b0, 1'b1, 5'd4},  // low byte masked out
    '{29'h4A5,     1'b0, 1'b0, 5'd0},  // masked bits differ
    '{29'h1234567, 1'b1, 1'b1, 5'd5},  // extended exact
    '{29'h1234567, 1'b0, 1'b0, 5'd0},  // extended required
    '{29'h3FF,     1'b1, 1'b0, 5'd0}   // mask compares extended flag
  };

  localparam logic [28:0] M8 = 29'h1FFFFF00;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 newdat_map", 64'(newdat_map), 0);
    chk("R1 txdone_map", 64'(txdone_map), 0);
    chk("R1 tx_pend", 64'(tx_pend), 0);
    chk("R1 rx_stored", 64'(rx_stored), 0);
    chk("R1 rx_lost", 64'(rx_lost), 0);
    chk("R1 irq", 64'(irq), 0);

    // Filter set-up: R2 R3 R6
    cfg_obj(0, 1, 0, 0, 29'h100, '0, 0, 0, 0, 0, 0, 0, 0, '0);
    cfg_obj(1, 0, 0, 0, 29'h200, '0, 0, 0, 0, 0, 0, 0, 0, '0);
    cfg_obj(2, 1, 1, 0, 29'h200, '0, 0, 0, 0, 0, 0, 0, 0, '0);
    cfg_obj(3, 1, 0, 0, 29'h200, '0, 0, 0, 1, 0, 0, 0, 0, '0);
    cfg_obj(4, 1, 0, 0, 29'h300, M8, 1, 1, 0, 0, 0, 0, 0, '0);
    cfg_obj(5, 1, 0, 1, 29'h1234567, '0, 0, 0, 1, 0, 0, 0, 0, '0);
    cfg_obj(6, 1, 0, 0, 29'h400, '0, 0, 0, 0, 0, 0, 0, 0, '0);

    for (int v = 0; v < NV; v++) begin
      send(RXV[v].id, RXV[v].xtd, 4'd8, 64'(v));
      chk($sformatf("R2 R3 R6 row %0d stored", v), 64'(rx_stored),
          64'(RXV[v].hit));
      if (RXV[v].hit) begin
        chk($sformatf("R2 row %0d object", v), 64'(rx_obj), 64'(RXV[v].obj));
        chk($sformatf("R9 row %0d newdat_map", v), 64'(newdat_map),
            64'(1) << RXV[v].obj);
        ack(int'(RXV[v].obj));
      end
    end

    // Chain of three, last one closes it: R4 R5
    cfg_obj(8,  1, 0, 0, 29'h555, '0, 0, 0, 0, 0, 0, 0, 0, '0);
    cfg_obj(9,  1, 0, 0, 29'h555, '0, 0, 0, 0, 0, 0, 0, 0, '0);
    cfg_obj(10, 1, 0, 0, 29'h555, '0, 0, 0, 1, 0, 0, 0, 0, '0);
    send(29'h555, 0, 4'd8, 64'hD1);
    chk("R4 first fill", 64'(rx_obj), 8);
    send(29'h555, 0, 4'd8, 64'hD2);
    chk("R4 second fill", 64'(rx_obj), 9);
    send(29'h555, 0, 4'd8, 64'hD3);
    chk("R4 third fill", 64'(rx_obj), 10);
    chk("R5 no loss yet", 64'(rx_lost), 0);
    send(29'h555, 0, 4'd6, 64'hD4);
    chk("R5 overwrite object", 64'(rx_obj), 10);
    chk("R5 rx_lost", 64'(rx_lost), 1);
    chk("R9 chain map", 64'(newdat_map), 64'h0700);
    readback(10);
    chk("R12 overwritten data", rd_data, 64'hD4);
    chk("R12 overwritten dlc", 64'(rd_dlc), 6);
    chk("R5 lost flag", 64'(rd_msglst), 1);
    readback(8);
    chk("R12 first data", rd_data, 64'hD1);
    chk("R12 stored id", 64'(rd_id), 64'h555);
    ack(8);
    send(29'h555, 0, 4'd8, 64'hD5);
    chk("R4 refill lowest free", 64'(rx_obj), 8);

    // Lone non-terminal object full: frame dropped (R5)
    cfg_obj(12, 1, 0, 0, 29'h666, '0, 0, 0, 0, 0, 0, 0, 0, '0);
    send(29'h666, 0, 4'd8, 64'hD6);
    chk("R5 lone store", 64'(rx_stored), 1);
    send(29'h666, 0, 4'd8, 64'hD7);
    chk("R5 dropped", 64'(rx_stored), 0);
    readback(12);
    chk("R5 untouched data", rd_data, 64'hD6);
    chk("R5 map kept", 64'(newdat_map), 64'h1700);

    // Acknowledge and store together: R11
    @(negedge clk);
    rx_valid = 1; rx_id = 29'h100; rx_xtd = 0; rx_dlc = 4'd1; rx_data = 64'hAA;
    clr_we = 1; clr_idx = 5'd0;
    @(negedge clk);
    rx_valid = 0; clr_we = 0;
    chk("R11 store beats clear", 64'(newdat_map), 64'h1701);
    ack(0);
    chk("R11 clear", 64'(newdat_map), 64'h1700);
    ack(10);
    readback(10);
    chk("R11 lost cleared", 64'(rd_msglst), 0);
    chk("R11 newdat cleared", 64'(rd_newdat), 0);
    chk("R10 rx enables off", 64'(irq), 0);

    // Transmit priority: R6 R7 R8 R9 R10
    cfg_obj(17, 0, 1, 0, 29'h001, '0, 0, 0, 0, 0, 1, 1, 4'd1, 64'h11);
    cfg_obj(20, 1, 1, 0, 29'h07A, '0, 0, 0, 0, 0, 0, 1, 4'd2, 64'hBEEF);
    cfg_obj(18, 1, 1, 1, 29'h012, '0, 0, 0, 0, 0, 1, 1, 4'd8,
            64'hDEADBEEF0BADF00D);
    @(negedge clk);
    chk("R7 tx_pend", 64'(tx_pend), 1);
    chk("R7 tx_obj", 64'(tx_obj), 18);
    chk("R7 tx_id", 64'(tx_id), 64'h012);
    chk("R7 tx_xtd", 64'(tx_xtd), 1);
    chk("R7 tx_dlc", 64'(tx_dlc), 8);
    chk("R7 tx_data", tx_data, 64'hDEADBEEF0BADF00D);
    finish_tx(18);
    chk("R8 next object", 64'(tx_obj), 20);
    chk("R8 next id", 64'(tx_id), 64'h07A);
    chk("R9 txdone_map", 64'(txdone_map), 64'h0004);
    chk("R10 tx irq", 64'(irq), 1);
    finish_tx(20);
    chk("R6 invalid not sent", 64'(tx_pend), 0);
    chk("R9 txdone_map two", 64'(txdone_map), 64'h0014);
    finish_tx(19);
    chk("R8 no request no effect", 64'(txdone_map), 64'h0014);
    ack(18);
    @(negedge clk);
    chk("R10 enable off", 64'(irq), 0);
    chk("R11 tx flag cleared", 64'(txdone_map), 64'h0010);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule